// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the serial side of a small configuration and status space. An external host drives chip select, serial clock and data in SPI mode 1. Clock polarity is 0 and data is captured on the falling clock edge. The host sends 16-bit frames. Each frame is either a command (read or write, plus a 14-bit address) or, right after a write command, the data word for that write. The block samples all three serial inputs into its own system clock domain through two-flop synchronisers and finds edges there. For that reason the system clock must run at least four times faster than the serial clock.

Every frame the host sends is answered one frame later. The response word loaded at the start of a frame is the result of the frame before it. A read returns the addressed value in the next frame. A write returns two words: the register's old value during the data frame, and its new value in the frame after that. Every response carries even parity and an error flag. A three-bit sticky error register records parity, address and framing faults, and clears itself when it is read. The register space holds:
- a no-operation address;
- the error register;
- a parameterised window of general 14-bit registers.

The serial link has no flow control. Back-pressure is not possible: the host paces every transfer, and the block only has to keep up with the serial clock.

Top module: `spi_regif_top`

## Requirements
- R1: MOSI is captured on falling SCLK edges, most significant bit first. MISO moves to its next bit after each rising SCLK edge, also most significant bit first.
- R2: `spi_miso_oe` is low after reset and whenever chip select is high. It goes high only while a frame is open, that is, between a falling and a rising edge of `spi_csn_n`.
- R3: A command word carries even parity over all 16 bits in bit 15, a read flag in bit 14 (1 = read, 0 = write) and the address in bits 13:0. The command takes effect only when chip select rises.
- R4: A response word carries even parity over all 16 bits in bit 15, an error flag in bit 14 and data in bits 13:0. It is shifted out in the frame that follows the command it answers. The first frame after reset returns 0x0000.
- R5: A write command is followed by a data frame (bit 15 even parity, bit 14 zero, bits 13:0 data). The data frame returns the register's old value, and the next frame returns its new value.
- R6: A command or data frame with odd parity sets error bit 2 and accesses nothing. The next response has error flag 1 and data 0.
- R7: An invalid address sets error bit 1 and accesses nothing. The next response has error flag 1 and data 0. Invalid addresses are those outside 0x0000, 0x0001 and the window 0x0010..0x0017, and any write to 0x0001.
- R8: A frame closed after a number of falling SCLK edges other than 16 sets error bit 0, is discarded, and cancels a pending write. The next response has error flag 1 and data 0.
- R9: Reading address 0x0001 returns the error register as {parity, address, framing} in data bits 2:0, then clears all three bits.
- R10: Address 0x0000 always reads as zero, and writes to it have no effect.
- R11: The window registers reset to zero and hold the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for MISO; low means high impedance |

## Verification
The hardest states to reach are the ones where a frame breaks while a write is half done. Examples are a write command followed by an over-long frame, and a data frame with a bad parity bit. Both leave the window register untouched, and both show up only through later reads. The stimulus makes the host model cut frames to 12 bits or stretch them to 20 bits, and flip bit 15 on chosen words. A read of the affected register then shows that nothing was written. A read of the error register follows, to show which flag was set and that the read cleared it.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 14;
  localparam int ADDR_W = 14;
  localparam logic [ADDR_W-1:0] NOP_ADDR = 14'h0000;
  localparam logic [ADDR_W-1:0] ERR_ADDR = 14'h0001;

  typedef logic [WORD_W-1:0] word_t;

  // Response word: even parity over the whole word, error flag, data.
  function automatic word_t pack_resp(input logic ef, input logic [DATA_W-1:0] d);
    return {^{ef, d}, ef, d};
  endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_n,
  input  logic sclk,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csn_rise,
  output logic csn_fall,
  output logic mosi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b100;  // csn idles high

  logic [NSIG-1:0] raw, synced;
  logic [STAGES-1:0] chain [NSIG];
  logic sclk_d, csn_d;

  assign raw = {csn_n, sclk, mosi};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= {STAGES{IDLE_VAL[g]}};
      else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[g][STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= synced[1];
      csn_d  <= synced[2];
    end
  end

  assign sclk_rise = synced[1] & ~sclk_d;
  assign sclk_fall = ~synced[1] & sclk_d;
  assign csn_rise  = synced[2] & ~csn_d;
  assign csn_fall  = ~synced[2] & csn_d;
  assign mosi_s    = synced[0];
endmodule

// File: rtl/spi_frame_io.sv
module spi_frame_io
  import spi_regif_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             csn_rise,
  input  logic             csn_fall,
  input  logic             mosi_s,
  input  word_t            resp_word,
  output logic             frame_done,
  output word_t            rx_word,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             miso,
  output logic             miso_oe
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

  logic  in_frame_q, miso_q;
  word_t rx_q, tx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      rx_q       <= '0;
      tx_q       <= '0;
      cnt_q      <= '0;
      miso_q     <= 1'b0;
    end else if (csn_fall) begin
      in_frame_q <= 1'b1;
      cnt_q      <= '0;
      tx_q       <= resp_word;
    end else if (csn_rise) begin
      in_frame_q <= 1'b0;
    end else if (in_frame_q) begin
      if (sclk_fall) begin
        rx_q <= {rx_q[WORD_W-2:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_rise) begin
        miso_q <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign frame_done = csn_rise & in_frame_q;
  assign rx_word    = rx_q;
  assign bit_cnt    = cnt_q;
  assign miso       = miso_q;
  assign miso_oe    = in_frame_q;

  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    csn_rise |=> !miso_oe);  // R2
  AST_TX_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    csn_fall |=> ~^tx_q);  // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);  // R8
endmodule

// File: rtl/spi_reg_core.sv
module spi_reg_core
  import spi_regif_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BASE_ADDR = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  word_t            rx_word,
  input  logic [CNT_W-1:0] bit_cnt,
  output word_t            resp_word
);
  logic              cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] wdata;
  logic len_ok, par_ok;

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [2:0]        err_q;      // {parity, address, framing}
  word_t             resp_q;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  logic              cmd_hit, pend_hit, addr_ok, do_write;
  logic              is_nop, is_err;
  logic [DATA_W-1:0] win_val, rd_val;
  logic [NUM_REGS-1:0] wr_sel;

  assign cmd_rd   = rx_word[WORD_W-2];
  assign cmd_addr = rx_word[ADDR_W-1:0];
  assign wdata    = rx_word[DATA_W-1:0];
  assign len_ok   = (bit_cnt == CNT_W'(WORD_W));
  assign par_ok   = ~^rx_word;

  always_comb begin
    cmd_hit = 1'b0;
    win_val = '0;
    wr_sel  = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cmd_addr == ADDR_W'(BASE_ADDR + i)) begin
        cmd_hit = 1'b1;
        win_val = regs_q[i];
      end
      if (pend_addr_q == ADDR_W'(BASE_ADDR + i)) wr_sel[i] = 1'b1;
    end
  end

  assign pend_hit = |wr_sel;
  assign is_nop   = (cmd_addr == NOP_ADDR);
  assign is_err   = (cmd_addr == ERR_ADDR);
  assign addr_ok  = is_nop | (is_err & cmd_rd) | cmd_hit;
  assign rd_val   = is_err  ? {{(DATA_W-3){1'b0}}, err_q} :
                    cmd_hit ? win_val : '0;
  assign do_write = frame_done & len_ok & pend_q & par_ok & pend_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (do_write) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_sel[i]) regs_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      err_q       <= '0;
      resp_q      <= '0;
    end else if (frame_done) begin
      if (!len_ok) begin
        err_q  <= err_q | 3'b001;
        pend_q <= 1'b0;
        resp_q <= pack_resp(1'b1, '0);
      end else if (pend_q) begin
        pend_q <= 1'b0;
        if (!par_ok) begin
          err_q  <= err_q | 3'b100;
          resp_q <= pack_resp(1'b1, '0);
        end else begin
          resp_q <= pack_resp(1'b0, pend_hit ? wdata : '0);
        end
      end else if (!par_ok) begin
        err_q  <= err_q | 3'b100;
        resp_q <= pack_resp(1'b1, '0);
      end else if (!addr_ok) begin
        err_q  <= err_q | 3'b010;
        resp_q <= pack_resp(1'b1, '0);
      end else begin
        resp_q <= pack_resp(1'b0, rd_val);
        if (cmd_rd && is_err) err_q <= '0;
        if (!cmd_rd) begin
          pend_q      <= 1'b1;
          pend_addr_q <= cmd_addr;
        end
      end
    end
  end

  assign resp_word = resp_q;

  AST_FRAMING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !len_ok) |=> err_q[0]);  // R8
  AST_FRAMING_CANCELS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !len_ok) |=> !pend_q);  // R8
  AST_CMD_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && len_ok && !pend_q && !par_ok) |=> (err_q[2] && resp_q[WORD_W-2]));  // R6
  AST_ERR_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && len_ok && !pend_q && par_ok && cmd_rd && is_err) |=> (err_q == 3'b000));  // R9
  AST_RESP_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ~^resp_q);  // R4
endmodule

// File: rtl/spi_regif_top.sv
module spi_regif_top #(
  parameter int NUM_REGS    = 8,
  parameter int BASE_ADDR   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  import spi_regif_pkg::*;
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic sclk_rise, sclk_fall, csn_rise, csn_fall, mosi_s, frame_done;
  word_t rx_word, resp_word;
  logic [CNT_W-1:0] bit_cnt;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .csn_n(spi_csn_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .csn_rise(csn_rise),
    .csn_fall(csn_fall), .mosi_s(mosi_s)
  );

  spi_frame_io #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .csn_rise(csn_rise), .csn_fall(csn_fall), .mosi_s(mosi_s),
    .resp_word(resp_word), .frame_done(frame_done), .rx_word(rx_word),
    .bit_cnt(bit_cnt), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_reg_core #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_word(rx_word),
    .bit_cnt(bit_cnt), .resp_word(resp_word)
  );
endmodule

// File: tb/sim_spi_regif_top.sv
`timescale 1ns/1ps
module sim_spi_regif_top;
  localparam int HALF = 8;           // system clocks per serial half period
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  spi_regif_top u0 (
    .clk(clk), .rst_n(rst_n), .spi_csn_n(csn), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  function automatic logic [15:0] cmdw(input logic rd, input logic [13:0] a);
    return {^{rd, a}, rd, a};
  endfunction
  function automatic logic [15:0] dataw(input logic [13:0] d);
    return {^d, 1'b0, d};
  endfunction
  function automatic logic [15:0] rsp(input logic ef, input logic [13:0] d);
    return {^{ef, d}, ef, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Host model: one frame of nbits clocks, MSB first, mode 1.
  task automatic spi_frame(input logic [15:0] w, input int nbits, output logic [15:0] got);
    got = '0;
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(miso_oe == 1'b1, "R2 oe high in frame", {15'b0, miso_oe}, 16'h1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = w[15 - (i % 16)];
      repeat (HALF) @(negedge clk);
      got = {got[14:0], miso};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    chk(miso_oe == 1'b0, "R2 oe low after frame", {15'b0, miso_oe}, 16'h0);
  endtask

  // Driver: runs a full frame and queues expected and observed words.
  task automatic xfer(input logic [15:0] w, input logic [15:0] exp, input string tag);
    logic [15:0] got;
    spi_frame(w, 16, got);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    act_q.push_back(got);
  endtask

  // Monitor: pops and compares in arrival order.
  always @(negedge clk) begin
    if (act_q.size() != 0 && exp_q.size() != 0) begin
      logic [15:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  initial begin
    logic [15:0] junk;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(miso_oe == 1'b0, "R2 oe low after reset", {15'b0, miso_oe}, 16'h0);

    // Read pipelining and write echo
    xfer(cmdw(1, 14'h10), 16'h0000, "R4 first response after reset zero");
    xfer(cmdw(0, 14'h11), rsp(0, 0), "R11 reg reset value zero");
    xfer(dataw(14'h1234), rsp(0, 0), "R5 old value during data frame");
    xfer(cmdw(0, 14'h11), rsp(0, 14'h1234), "R5 new value after data frame");
    xfer(dataw(14'h0ABC), rsp(0, 14'h1234), "R5 nonzero old value echo");
    xfer(cmdw(1, 14'h11), rsp(0, 14'h0ABC), "R5 second new value");
    xfer(cmdw(1, 14'h10), rsp(0, 14'h0ABC), "R4 R11 read returned one frame late");

    // Command parity error
    xfer(cmdw(1, 14'h10) ^ 16'h8000, rsp(0, 0), "R11 other reg still zero");
    xfer(cmdw(1, 14'h01), rsp(1, 0), "R6 error flag after bad command parity");
    xfer(cmdw(1, 14'h01), rsp(0, 14'h0004), "R6 R9 parity bit in error register");
    xfer(cmdw(1, 14'h00), rsp(0, 0), "R9 error register cleared by read");

    // No-operation address
    xfer(cmdw(0, 14'h00), rsp(0, 0), "R10 nop reads zero");
    xfer(dataw(14'h3FFF), rsp(0, 0), "R10 nop old value zero");
    xfer(cmdw(1, 14'h00), rsp(0, 0), "R10 nop new value zero");

    // Invalid addresses
    xfer(cmdw(1, 14'h0100), rsp(0, 0), "R10 nop write had no effect");
    xfer(cmdw(0, 14'h01), rsp(1, 0), "R7 error flag after unmapped read");
    xfer(cmdw(1, 14'h01), rsp(1, 0), "R7 error flag after write to error register");
    xfer(cmdw(1, 14'h10), rsp(0, 14'h0002), "R7 R9 address bit in error register");

    // Framing: short frame, then long frame cancelling a write
    spi_frame(cmdw(0, 14'h10), 12, junk);
    xfer(cmdw(1, 14'h10), rsp(1, 0), "R8 error flag after short frame");
    xfer(cmdw(0, 14'h10), rsp(0, 0), "R8 short frame accessed nothing");
    spi_frame(dataw(14'h2222), 20, junk);
    xfer(cmdw(1, 14'h10), rsp(1, 0), "R8 error flag after long frame");
    xfer(cmdw(1, 14'h01), rsp(0, 0), "R8 pending write cancelled");
    xfer(cmdw(1, 14'h00), rsp(0, 14'h0001), "R8 R9 framing bit in error register");

    // Data frame parity error
    xfer(cmdw(0, 14'h12), rsp(0, 0), "R9 framing bit cleared");
    xfer(dataw(14'h0555) ^ 16'h8000, rsp(0, 0), "R5 old value of reg2");
    xfer(cmdw(1, 14'h12), rsp(1, 0), "R6 error flag after bad data parity");
    xfer(cmdw(1, 14'h01), rsp(0, 0), "R6 reg2 not written");
    xfer(cmdw(1, 14'h00), rsp(0, 14'h0004), "R6 parity bit from data frame");

    // Window edge and bit order
    xfer(cmdw(0, 14'h17), rsp(0, 0), "R9 cleared before top reg write");
    xfer(dataw(14'h2D0F), rsp(0, 0), "R11 top reg old value");
    xfer(cmdw(1, 14'h17), rsp(0, 14'h2D0F), "R1 R3 bit order of written word");
    xfer(cmdw(1, 14'h18), rsp(0, 14'h2D0F), "R3 top reg read back");
    xfer(cmdw(1, 14'h00), rsp(1, 0), "R7 address just past window");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule